// File: doc/BRIEF.md
# DMA Channel Register Bank

This block is the programmable face of a multi-channel DMA controller. A host reaches it over a simple 32-bit register bus. The bus has a word address, a write enable with write data, and a read strobe that returns data one cycle later. Each channel has four registers: two addresses and two control words. The transfer engines take their programming from dedicated output buses. The moment a host arms a channel, the engine for that channel receives a single-cycle start pulse.

Each engine returns a done pulse when it finishes. The bank then clears that channel's enable bit. If the channel asked for a completion interrupt, the bank also latches a per-channel status bit. The status register is shared by all channels and is cleared by writing ones to it. An unmask register gates these bits onto one level-sensitive interrupt line.

A global configuration word holds the arbitration selection. It also reports a fixed revision code and a code for the channel count. Three read-only words mirror the engines' request, acknowledge and finish lines. The data movers themselves live outside this block.

Top module: `dma_regbank`

## Requirements
- R1: Channel n (n < NUM_CH) owns four registers at word index 4n+k: k=0 source address, k=1 destination address, k=2 control word 0, k=3 control word 1. Source and destination store all 32 bits, and no channel's writes alter another channel's registers.
- R2: Control word 0 stores bits 31:16 (length) and bits 7:0. Within bits 7:0, bit 7 is source fixed, bit 6 is destination fixed, bits 5:3 are the burst code, bit 2 is done-interrupt enable, bit 1 is enable and bit 0 is memory-to-memory mode. Bits 15:8 read the channel's 8-bit current-position input and ignore writes.
- R3: A write to control word 0 with bit 1 set makes bit 1 read 1. It also drives that channel's eng_start high for exactly the one cycle after the write edge, and no other channel's start.
- R4: A done pulse on a channel clears its enable bit at the next edge. A write to control word 0 with bit 1 clear also clears enable (abort), and that write issues no start pulse.
- R5: Control word 1 stores bits 21:16 (source request select), 13:8 (destination request select), 7:3 (next channel), bit 2 (coherent), bit 1 (fail) and bit 0 (mask). All other bits read 0.
- R6: The done status register sits at word 0x81 (byte offset 0x204), with bit n for channel n. A done pulse sets bit n only when that channel's done-interrupt enable is 1. Writing 1 to a bit clears it and writing 0 leaves it unchanged. A done pulse in the same cycle as a clearing write leaves the bit set.
- R7: The unmask register sits at word 0x80 (byte offset 0x200) and holds NUM_CH bits. irq is 1 exactly when some status bit and its unmask bit are both 1. irq follows the register state in the cycle after the edge that changed it.
- R8: The configuration word sits at word 0x88 (byte offset 0x220). Bit 0 is read/write and drives rr_mode, where 1 selects round-robin arbitration. Bits 2:1 read the REVISION parameter and bits 4:3 read code c, where NUM_CH = 8<<c. Writes to bits 31:1 have no effect.
- R9: Words 0xA8, 0xA9 and 0xAA (byte offsets 0x2A0, 0x2A4, 0x2A8) read eng_req, eng_ack and eng_fin, one bit per channel. They are read-only.
- R10: Every other word address reads 0, and writes to such an address change no register.
- R11: bus_rdata is loaded at the edge that samples bus_rd_en and holds otherwise. After reset, all stored registers are 0 and eng_start and irq are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_word_addr | input | WADDR_W | Word address (byte offset / 4) |
| bus_wr_en | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data |
| bus_rd_en | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid the cycle after the strobe |
| eng_done | input | NUM_CH | Per-channel done pulses |
| eng_cur_pos | input | NUM_CH*8 | Per-channel current position, 8 bits each |
| eng_req | input | NUM_CH | Request status lines |
| eng_ack | input | NUM_CH | Acknowledge status lines |
| eng_fin | input | NUM_CH | Finish status lines |
| eng_start | output | NUM_CH | Per-channel start pulses |
| ch_src | output | NUM_CH*32 | Source addresses, channel n at bits 32n+31:32n |
| ch_dst | output | NUM_CH*32 | Destination addresses |
| ch_ctrl0 | output | NUM_CH*32 | Stored control word 0 per channel |
| ch_ctrl1 | output | NUM_CH*32 | Stored control word 1 per channel |
| rr_mode | output | 1 | Round-robin arbitration selected |
| irq | output | 1 | Level interrupt |

## Verification
A write lands at the edge that samples it. The start pulse, the new register contents and any change in irq are therefore all due in the cycle after that edge. A read result is due one edge after the strobe. A done pulse affects enable, status and irq at the edge that samples it. The bench drives every input on the falling edge and samples the port it checks on the next falling edge, which is exactly one rising edge later. It checks a start pulse both in its own cycle and in the cycle after, so any pulse that is late or lasts too long is caught.

// File: rtl/dma_regbank_pkg.sv
package dma_regbank_pkg;

  localparam int unsigned REG_W = 32;

  // word indices of the shared registers (byte offset / 4)
  localparam logic [9:0] W_UNMASK = 10'h080;
  localparam logic [9:0] W_DONE   = 10'h081;
  localparam logic [9:0] W_CFG    = 10'h088;
  localparam logic [9:0] W_REQ    = 10'h0A8;
  localparam logic [9:0] W_ACK    = 10'h0A9;
  localparam logic [9:0] W_FIN    = 10'h0AA;

  typedef enum logic [1:0] {
    CR_SRC  = 2'd0,
    CR_DST  = 2'd1,
    CR_CTL0 = 2'd2,
    CR_CTL1 = 2'd3
  } chan_reg_e;

  localparam logic [REG_W-1:0] CTL0_KEEP = 32'hFFFF_00FF;
  localparam logic [REG_W-1:0] CTL1_KEEP = 32'h003F_3FFF;
  localparam int unsigned CTL0_EN = 1;
  localparam int unsigned CTL0_IE = 2;

endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_regbank_pkg::*;
#(
  parameter int unsigned POS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  logic             wr_en,
  input  logic [1:0]       reg_sel,
  input  logic [REG_W-1:0] wdata,
  input  logic             done_i,
  input  logic [POS_W-1:0] cur_pos,
  output logic [REG_W-1:0] src_o,
  output logic [REG_W-1:0] dst_o,
  output logic [REG_W-1:0] ctl0_o,
  output logic [REG_W-1:0] ctl1_o,
  output logic [REG_W-1:0] rd_o,
  output logic             start_o,
  output logic             done_set_o
);

  logic wr;
  assign wr = sel && wr_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_o   <= '0;
      dst_o   <= '0;
      ctl0_o  <= '0;
      ctl1_o  <= '0;
      start_o <= 1'b0;
    end else begin
      start_o <= 1'b0;
      if (wr && reg_sel == CR_SRC)  src_o  <= wdata;
      if (wr && reg_sel == CR_DST)  dst_o  <= wdata;
      if (wr && reg_sel == CR_CTL1) ctl1_o <= wdata & CTL1_KEEP;
      if (wr && reg_sel == CR_CTL0) begin
        ctl0_o  <= wdata & CTL0_KEEP;
        start_o <= wdata[CTL0_EN];
      end else if (done_i) begin
        ctl0_o[CTL0_EN] <= 1'b0;
      end
    end
  end

  assign done_set_o = done_i && ctl0_o[CTL0_IE];

  always_comb begin
    unique case (reg_sel)
      CR_SRC:  rd_o = src_o;
      CR_DST:  rd_o = dst_o;
      CR_CTL0: rd_o = {ctl0_o[31:16], cur_pos, ctl0_o[7:0]};
      default: rd_o = ctl1_o;
    endcase
  end

endmodule

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl #(
  parameter int unsigned NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_unmask,
  input  logic              wr_done,
  input  logic [NUM_CH-1:0] wbits,
  input  logic [NUM_CH-1:0] done_set,
  output logic [NUM_CH-1:0] status_o,
  output logic [NUM_CH-1:0] unmask_o,
  output logic              irq_o
);

  logic [NUM_CH-1:0] clr;
  assign clr = wr_done ? wbits : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_o <= '0;
      unmask_o <= '0;
    end else begin
      status_o <= (status_o & ~clr) | done_set;
      if (wr_unmask) unmask_o <= wbits;
    end
  end

  assign irq_o = |(status_o & unmask_o);

endmodule

// File: rtl/dma_regbank.sv
module dma_regbank
  import dma_regbank_pkg::*;
#(
  parameter int unsigned NUM_CH   = 8,
  parameter int unsigned WADDR_W  = 10,
  parameter logic [1:0]  REVISION = 2'd1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [WADDR_W-1:0]      bus_word_addr,
  input  logic                    bus_wr_en,
  input  logic [31:0]             bus_wdata,
  input  logic                    bus_rd_en,
  output logic [31:0]             bus_rdata,
  input  logic [NUM_CH-1:0]       eng_done,
  input  logic [NUM_CH*8-1:0]     eng_cur_pos,
  input  logic [NUM_CH-1:0]       eng_req,
  input  logic [NUM_CH-1:0]       eng_ack,
  input  logic [NUM_CH-1:0]       eng_fin,
  output logic [NUM_CH-1:0]       eng_start,
  output logic [NUM_CH*32-1:0]    ch_src,
  output logic [NUM_CH*32-1:0]    ch_dst,
  output logic [NUM_CH*32-1:0]    ch_ctrl0,
  output logic [NUM_CH*32-1:0]    ch_ctrl1,
  output logic                    rr_mode,
  output logic                    irq
);

  localparam int unsigned IDX_W   = $clog2(NUM_CH);
  localparam int unsigned SPAN_W  = IDX_W + 2;
  localparam logic [1:0]  CH_CODE = 2'($clog2(NUM_CH / 8));

  logic              chan_hit;
  logic [IDX_W-1:0]  ch_idx;
  logic [1:0]        reg_sel;
  logic [REG_W-1:0]  chan_rd [NUM_CH];
  logic [NUM_CH-1:0] done_set;
  logic [NUM_CH-1:0] status;
  logic [NUM_CH-1:0] unmask;
  logic              hit_unmask, hit_done, hit_cfg;
  logic              rr_q;
  logic [31:0]       rd_next;

  assign chan_hit   = (bus_word_addr[WADDR_W-1:SPAN_W] == '0);
  assign ch_idx     = bus_word_addr[SPAN_W-1:2];
  assign reg_sel    = bus_word_addr[1:0];
  assign hit_unmask = (bus_word_addr == WADDR_W'(W_UNMASK));
  assign hit_done   = (bus_word_addr == WADDR_W'(W_DONE));
  assign hit_cfg    = (bus_word_addr == WADDR_W'(W_CFG));

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    dma_chan_regs #(.POS_W(8)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .sel        (chan_hit && ch_idx == IDX_W'(g)),
      .wr_en      (bus_wr_en),
      .reg_sel    (reg_sel),
      .wdata      (bus_wdata),
      .done_i     (eng_done[g]),
      .cur_pos    (eng_cur_pos[g*8 +: 8]),
      .src_o      (ch_src[g*32 +: 32]),
      .dst_o      (ch_dst[g*32 +: 32]),
      .ctl0_o     (ch_ctrl0[g*32 +: 32]),
      .ctl1_o     (ch_ctrl1[g*32 +: 32]),
      .rd_o       (chan_rd[g]),
      .start_o    (eng_start[g]),
      .done_set_o (done_set[g])
    );
  end

  dma_irq_ctrl #(.NUM_CH(NUM_CH)) u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_unmask (bus_wr_en && hit_unmask),
    .wr_done   (bus_wr_en && hit_done),
    .wbits     (bus_wdata[NUM_CH-1:0]),
    .done_set  (done_set),
    .status_o  (status),
    .unmask_o  (unmask),
    .irq_o     (irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      rr_q <= 1'b0;
    else if (bus_wr_en && hit_cfg)   rr_q <= bus_wdata[0];
  end
  assign rr_mode = rr_q;

  always_comb begin
    rd_next = '0;
    if (chan_hit)                                      rd_next = chan_rd[ch_idx];
    else if (hit_unmask)                               rd_next = 32'(unmask);
    else if (hit_done)                                 rd_next = 32'(status);
    else if (hit_cfg)                                  rd_next = {27'd0, CH_CODE, REVISION, rr_q};
    else if (bus_word_addr == WADDR_W'(W_REQ))         rd_next = 32'(eng_req);
    else if (bus_word_addr == WADDR_W'(W_ACK))         rd_next = 32'(eng_ack);
    else if (bus_word_addr == WADDR_W'(W_FIN))         rd_next = 32'(eng_fin);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         bus_rdata <= '0;
    else if (bus_rd_en) bus_rdata <= rd_next;
  end

endmodule

// File: rtl/dma_regbank_chk.sv
module dma_regbank_chk #(
  parameter int unsigned NUM_CH  = 8,
  parameter int unsigned WADDR_W = 10
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [WADDR_W-1:0]   bus_word_addr,
  input logic                 bus_wr_en,
  input logic                 bus_rd_en,
  input logic [31:0]          bus_rdata,
  input logic [NUM_CH-1:0]    eng_done,
  input logic [NUM_CH-1:0]    eng_start,
  input logic [NUM_CH*32-1:0] ch_ctrl0,
  input logic                 irq
);

  logic mapped, unmapped;
  logic unused_ctl;
  assign unused_ctl = ^ch_ctrl0;

  always_comb begin
    mapped = (32'(bus_word_addr) < NUM_CH * 4);
    case (32'(bus_word_addr))
      32'h80, 32'h81, 32'h88, 32'hA8, 32'hA9, 32'hAA: mapped = 1'b1;
      default: ;
    endcase
    unmapped = !mapped;
  end

  AST_START_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_start & $past(eng_start)) == '0); // R3

  AST_START_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (|eng_start) |-> $past(bus_wr_en)); // R3

  AST_IRQ_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(|eng_done) || $past(bus_wr_en))); // R7

  AST_IRQ_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(bus_wr_en)); // R6

  AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd_en && unmapped) |=> (bus_rdata == '0)); // R10

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    AST_DONE_DROPS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_done[g] && !bus_wr_en) |=> !ch_ctrl0[g*32+1]); // R4
  end

endmodule

bind dma_regbank dma_regbank_chk #(.NUM_CH(NUM_CH), .WADDR_W(WADDR_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .bus_word_addr (bus_word_addr),
  .bus_wr_en     (bus_wr_en),
  .bus_rd_en     (bus_rd_en),
  .bus_rdata     (bus_rdata),
  .eng_done      (eng_done),
  .eng_start     (eng_start),
  .ch_ctrl0      (ch_ctrl0),
  .irq           (irq)
);

// File: tb/tb_dma_regbank.sv
`timescale 1ns/1ps
module tb_dma_regbank;

  localparam int NCH = 8;
  localparam int AW  = 10;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [AW-1:0]     bus_word_addr = '0;
  logic              bus_wr_en = 1'b0;
  logic [31:0]       bus_wdata = '0;
  logic              bus_rd_en = 1'b0;
  logic [31:0]       bus_rdata;
  logic [NCH-1:0]    eng_done = '0;
  logic [NCH*8-1:0]  eng_cur_pos;
  logic [NCH-1:0]    eng_req = '0, eng_ack = '0, eng_fin = '0;
  logic [NCH-1:0]    eng_start;
  logic [NCH*32-1:0] ch_src, ch_dst, ch_ctrl0, ch_ctrl1;
  logic              rr_mode, irq;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  dma_regbank #(.NUM_CH(NCH), .WADDR_W(AW), .REVISION(2'd1)) dut (
    .clk(clk), .rst_n(rst_n), .bus_word_addr(bus_word_addr), .bus_wr_en(bus_wr_en),
    .bus_wdata(bus_wdata), .bus_rd_en(bus_rd_en), .bus_rdata(bus_rdata),
    .eng_done(eng_done), .eng_cur_pos(eng_cur_pos), .eng_req(eng_req),
    .eng_ack(eng_ack), .eng_fin(eng_fin), .eng_start(eng_start),
    .ch_src(ch_src), .ch_dst(ch_dst), .ch_ctrl0(ch_ctrl0), .ch_ctrl1(ch_ctrl1),
    .rr_mode(rr_mode), .irq(irq)
  );

  function automatic logic [7:0] cpos(int ch);
    return 8'(8'h40 + ch * 3);
  endfunction

  function automatic logic [31:0] exp_c0(logic [31:0] w, int ch);
    return (w & 32'hFFFF_00FF) | (32'(cpos(ch)) << 8);
  endfunction

  function automatic logic [31:0] pat(int ch, int r);
    return 32'h9E37_79B9 ^ (32'(ch) << 20) ^ (32'(r) << 9) ^ (32'(ch * 7 + r) << 1);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input int wa, input logic [31:0] d);
    @(negedge clk);
    bus_word_addr = AW'(wa); bus_wr_en = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_wr_en = 1'b0;
  endtask

  task automatic rd(input int wa, output logic [31:0] d);
    @(negedge clk);
    bus_word_addr = AW'(wa); bus_rd_en = 1'b1;
    @(negedge clk);
    bus_rd_en = 1'b0;
    d = bus_rdata;
  endtask

  task automatic pulse_done(input logic [NCH-1:0] m);
    @(negedge clk);
    eng_done = m;
    @(negedge clk);
    eng_done = '0;
  endtask

  task automatic finish_run();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    for (int c = 0; c < NCH; c++) eng_cur_pos[c*8 +: 8] = cpos(c);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11: reset state
    chk("R11 start", 32'(eng_start), 0);
    chk("R11 irq", 32'(irq), 0);
    for (int c = 0; c < NCH; c++)
      for (int r = 0; r < 4; r++) begin
        rd(c * 4 + r, v);
        chk("R11 reset reg", v, (r == 2) ? exp_c0(0, c) : 32'h0);
      end

    // R1 R2 R5: fill every register, then read all back
    for (int c = 0; c < NCH; c++)
      for (int r = 0; r < 4; r++)
        wr(c * 4 + r, (r == 2) ? (pat(c, r) & ~32'h2) : pat(c, r));
    for (int c = 0; c < NCH; c++)
      for (int r = 0; r < 4; r++) begin
        rd(c * 4 + r, v);
        case (r)
          0, 1: chk("R1 address regs", v, pat(c, r));
          2:    chk("R2 ctrl0 fields", v, exp_c0(pat(c, r) & ~32'h2, c));
          default: chk("R5 ctrl1 fields", v, pat(c, r) & 32'h003F_3FFF);
        endcase
      end

    // R3 R4 R6 R7: per-channel start, done, status, clear
    wr(32'h80, 32'hFF);
    for (int c = 0; c < NCH; c++) begin
      wr(c * 4 + 2, 32'h0010_0006);
      chk("R3 start pulse", 32'(eng_start), 32'(1) << c);
      @(negedge clk);
      chk("R3 start one cycle", 32'(eng_start), 0);
      rd(c * 4 + 2, v);
      chk("R3 enable reads 1", v, exp_c0(32'h0010_0006, c));
      pulse_done(NCH'(1) << c);
      chk("R7 irq on", 32'(irq), 1);
      rd(c * 4 + 2, v);
      chk("R4 done clears enable", v, exp_c0(32'h0010_0004, c));
      rd(32'h81, v);
      chk("R6 status set", v, 32'(1) << c);
      wr(32'h81, 32'h0);
      rd(32'h81, v);
      chk("R6 write 0 keeps", v, 32'(1) << c);
      wr(32'h81, 32'(1) << c);
      chk("R7 irq off", 32'(irq), 0);
      rd(32'h81, v);
      chk("R6 w1c", v, 0);
    end

    // R7: masked status keeps irq low
    wr(32'h80, 32'h00);
    pulse_done(8'h01);
    chk("R7 masked", 32'(irq), 0);
    wr(32'h80, 32'h01);
    chk("R7 unmask raises", 32'(irq), 1);
    rd(32'h80, v);
    chk("R7 unmask readback", v, 32'h01);
    wr(32'h81, 32'h01);

    // R6: done without interrupt enable
    wr(5 * 4 + 2, 32'h0000_0002);
    pulse_done(8'h20);
    rd(32'h81, v);
    chk("R6 no ie no status", v, 0);
    rd(5 * 4 + 2, v);
    chk("R4 done clears no-ie", v, exp_c0(0, 5));

    // R4: abort without start
    wr(6 * 4 + 2, 32'h0000_0006);
    @(negedge clk);
    wr(6 * 4 + 2, 32'h0000_0004);
    chk("R4 abort no start", 32'(eng_start), 0);
    rd(6 * 4 + 2, v);
    chk("R4 abort clears", v, exp_c0(32'h4, 6));

    // R6: set wins over simultaneous clear
    wr(1 * 4 + 2, 32'h0000_0004);
    pulse_done(8'h02);
    @(negedge clk);
    bus_word_addr = AW'(32'h81); bus_wr_en = 1'b1; bus_wdata = 32'h02; eng_done = 8'h02;
    @(negedge clk);
    bus_wr_en = 1'b0; eng_done = '0;
    rd(32'h81, v);
    chk("R6 set beats clear", v, 32'h02);
    wr(32'h81, 32'h02);

    // R8: configuration
    rd(32'h88, v);
    chk("R8 cfg reset", v, 32'h2);
    wr(32'h88, 32'hFFFF_FFFF);
    rd(32'h88, v);
    chk("R8 cfg ro fields", v, 32'h3);
    chk("R8 rr_mode", 32'(rr_mode), 1);

    // R9: status mirrors
    eng_req = 8'h5A; eng_ack = 8'hC3; eng_fin = 8'h81;
    rd(32'hA8, v); chk("R9 req", v, 32'h5A);
    rd(32'hA9, v); chk("R9 ack", v, 32'hC3);
    rd(32'hAA, v); chk("R9 fin", v, 32'h81);
    wr(32'hA8, 32'h0);
    rd(32'hA8, v); chk("R9 read-only", v, 32'h5A);

    // R10: unmapped space
    wr(32'h20, 32'hFFFF_FFFF);
    wr(32'h40, 32'hFFFF_FFFF);
    wr(32'h82, 32'hFFFF_FFFF);
    rd(32'h20, v); chk("R10 read 0x20", v, 0);
    rd(32'h40, v); chk("R10 read 0x40", v, 0);
    rd(32'h82, v); chk("R10 read 0x82", v, 0);
    rd(32'h3FF, v); chk("R10 read top", v, 0);
    rd(0, v); chk("R10 no alias ch0", v, pat(0, 0));
    rd(32'h80, v); chk("R10 unmask kept", v, 32'h01);

    // R11: rdata holds without strobe
    @(negedge clk);
    bus_word_addr = AW'(32'h88);
    @(negedge clk);
    chk("R11 rdata holds", bus_rdata, 32'h01);

    finish_run();
  end

endmodule